// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the combinational arithmetic and logic unit of a small 8-bit microcontroller core. In one evaluation it takes a destination operand, a second operand (a register value or an immediate that decode has already placed on the same input), the current 8-bit status register and an operation code. It returns the result byte, the updated status register and a write-enable telling the register file whether the result is to be stored.

Nine operations are supported: add with carry, compare with carry, compare with immediate, subtract immediate with carry, increment, logical shift right, rotate right through carry, two's-complement negate and nibble swap. The two compares update the flags only. Multi-byte compares and subtractions chain through the carry, and the zero flag is sticky across the chain, so a multi-byte value reads as zero only when every byte was zero. Register file, decode and memory access are outside the block.

All the arithmetic shares one adder/subtractor with operand steering in front of it. The shift, rotate and swap paths are separate. A flag assembly stage picks the result and builds the new status byte.

Top module: `alu8_core`

## Requirements
- R1: Status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. Bits T and I of the output always equal the input bits, for every operation code.
- R2: Code 0 (add with carry) gives res = dst + src + C modulo 256 and sets we. C is the carry out of bit 7 and H the carry out of bit 3. V is set on two's-complement overflow. N is bit 7 of the result, Z is set when the result is zero, and S = N xor V.
- R3: Codes 1 (compare with carry), 2 (compare immediate) and 3 (subtract immediate with carry) compute res = dst - src - k modulo 256, where k is the input C for codes 1 and 3 and k = 0 for code 2. C is the borrow out of bit 7 and H the borrow out of bit 3. V is set on signed overflow, N is bit 7 of the result and S = N xor V.
- R4: Codes 1 and 2 hold we low and still drive the difference on res. Code 3 sets we.
- R5: For codes 1 and 3, Z out = Z in AND (result is zero), so these codes can clear Z but never set it. For code 2, Z is simply set when the result is zero.
- R6: Code 4 (increment) gives res = dst + 1 modulo 256 and sets we. V is set only when dst is 0x7F, and N, Z and S follow the result. C and H are left unchanged.
- R7: Code 5 (logical shift right) gives res = dst >> 1 with a 0 in bit 7 and sets we. C takes dst bit 0, N is 0, V = N xor C, S = N xor V, Z follows the result, and H is unchanged.
- R8: Code 6 (rotate right through carry) puts the input C in bit 7 and dst bits 7..1 below it, and sets we. C takes dst bit 0, N is result bit 7, V = N xor C, S = N xor V, Z follows the result, and H is unchanged.
- R9: Code 7 (negate) gives res = 0 - dst modulo 256 and sets we. C is set when dst is nonzero, V when dst is 0x80, and H on a borrow out of bit 3 (dst low nibble nonzero). N, Z and S follow as for a subtraction.
- R10: Code 8 (nibble swap) exchanges the upper and lower four bits of dst, sets we, and returns the status register unchanged.
- R11: Codes 9 to 15 are unused. They drive res = 0, hold we low and return the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (see requirements) |
| dst_i | input | W (8) | Destination operand |
| src_i | input | W (8) | Source register or immediate operand |
| sreg_i | input | 8 | Current status register |
| res_o | output | W (8) | Result byte |
| sreg_o | output | 8 | Updated status register |
| we_o | output | 1 | Result write-enable |

## Verification
Every destination value is swept for every operation, under all four combinations of input carry and zero. The binary operations are paired with a set of second operands that includes the carry and sign boundaries (0x00, 0x01, 0x0F, 0x10, 0x7F, 0x80, 0xFE, 0xFF). This catches a half-carry taken from the wrong bit, which flips H on nibble-boundary values, and a subtraction that ignores the incoming carry, which is off by one whenever C is set. It also catches a non-sticky zero in the chained compare, which reports equality of a multi-byte value whose upper bytes differ, and an increment that disturbs C, which breaks multi-byte counting loops. Directed vectors cover the shift flag rule V = N xor C, rotation of the old carry into bit 7, negation of 0x80 and 0x00, and swap and unused codes leaving every flag untouched.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;

   typedef enum logic [3:0] {
      OP_ADDC  = 4'd0,
      OP_CMPC  = 4'd1,
      OP_CMPI  = 4'd2,
      OP_SUBIC = 4'd3,
      OP_INC   = 4'd4,
      OP_SHR   = 4'd5,
      OP_RORC  = 4'd6,
      OP_NEG   = 4'd7,
      OP_SWAP  = 4'd8
   } alu_op_e;

   // status register bit positions
   localparam int SB_C = 0;
   localparam int SB_Z = 1;
   localparam int SB_N = 2;
   localparam int SB_V = 3;
   localparam int SB_S = 4;
   localparam int SB_H = 5;
   localparam int SB_T = 6;
   localparam int SB_I = 7;
   localparam int SREG_W = 8;

   // steering of the shared adder/subtractor
   typedef struct packed {
      logic sub;
      logic use_cin;
      logic zero_a;
      logic one_b;
      logic swap_ab;
   } as_ctl_t;

endpackage

// File: rtl/alu8_addsub.sv
`timescale 1ns/1ps
module alu8_addsub #(
   parameter int W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   input  logic         sub_i,
   output logic [W-1:0] sum_o,
   output logic         co_o,
   output logic         hc_o,
   output logic         ovf_o
);
   localparam int HALF = W / 2;

   generate
      if (W < 4 || (W % 2) != 0) begin : g_bad_w
         $error("alu8_addsub: W must be even and at least 4");
      end
   endgenerate

   logic [W:0]    wide;
   logic [HALF:0] low;

   always_comb begin
      if (sub_i) begin
         wide  = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
         low   = {1'b0, a_i[HALF-1:0]} - {1'b0, b_i[HALF-1:0]} - {{HALF{1'b0}}, cin_i};
         ovf_o = (a_i[W-1] != b_i[W-1]) && (wide[W-1] != a_i[W-1]);
      end else begin
         wide  = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
         low   = {1'b0, a_i[HALF-1:0]} + {1'b0, b_i[HALF-1:0]} + {{HALF{1'b0}}, cin_i};
         ovf_o = (a_i[W-1] == b_i[W-1]) && (wide[W-1] != a_i[W-1]);
      end
      sum_o = wide[W-1:0];
      co_o  = wide[W];
      hc_o  = low[HALF];

      if (!$isunknown({a_i, b_i, cin_i, sub_i})) begin
         // R3
         if (sub_i && !cin_i && (a_i == b_i)) begin
            sub_equal_chk: assert (sum_o == '0 && !co_o && !hc_o && !ovf_o)
               else $error("equal operands did not subtract to a clean zero");
         end
      end
   end

endmodule

// File: rtl/alu8_shift.sv
`timescale 1ns/1ps
module alu8_shift #(
   parameter int W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic         cin_i,
   output logic [W-1:0] shr_o,
   output logic [W-1:0] ror_o,
   output logic [W-1:0] swp_o,
   output logic         out_bit_o
);
   localparam int HALF = W / 2;

   generate
      if (W < 4 || (W % 2) != 0) begin : g_bad_w
         $error("alu8_shift: W must be even and at least 4");
      end
      for (genvar i = 0; i < W; i++) begin : g_swap
         assign swp_o[i] = a_i[(i + HALF) % W];
      end
   endgenerate

   assign shr_o     = {1'b0, a_i[W-1:1]};
   assign ror_o     = {cin_i, a_i[W-1:1]};
   assign out_bit_o = a_i[0];

endmodule

// File: rtl/alu8_flagmux.sv
`timescale 1ns/1ps
module alu8_flagmux
   import alu8_pkg::*;
#(
   parameter int W = 8
) (
   input  alu_op_e             op_i,
   input  logic [SREG_W-1:0]   sreg_i,
   input  logic [W-1:0]        as_sum_i,
   input  logic                as_co_i,
   input  logic                as_hc_i,
   input  logic                as_ovf_i,
   input  logic [W-1:0]        shr_i,
   input  logic [W-1:0]        ror_i,
   input  logic [W-1:0]        swp_i,
   input  logic                sh_bit_i,
   output logic [W-1:0]        res_o,
   output logic [SREG_W-1:0]   sreg_o,
   output logic                we_o
);
   logic zero_as, zero_shr, zero_ror;

   assign zero_as  = (as_sum_i == '0);
   assign zero_shr = (shr_i == '0);
   assign zero_ror = (ror_i == '0);

   always_comb begin
      sreg_o = sreg_i;
      res_o  = '0;
      we_o   = 1'b0;
      unique case (op_i)
         OP_ADDC, OP_CMPC, OP_CMPI, OP_SUBIC, OP_NEG: begin
            res_o        = as_sum_i;
            we_o         = (op_i == OP_ADDC) || (op_i == OP_SUBIC) || (op_i == OP_NEG);
            sreg_o[SB_C] = as_co_i;
            sreg_o[SB_H] = as_hc_i;
            sreg_o[SB_V] = as_ovf_i;
            sreg_o[SB_N] = as_sum_i[W-1];
            sreg_o[SB_S] = as_sum_i[W-1] ^ as_ovf_i;
            if (op_i == OP_CMPC || op_i == OP_SUBIC)
               sreg_o[SB_Z] = sreg_i[SB_Z] & zero_as;
            else
               sreg_o[SB_Z] = zero_as;
         end
         OP_INC: begin
            res_o        = as_sum_i;
            we_o         = 1'b1;
            sreg_o[SB_V] = as_ovf_i;
            sreg_o[SB_N] = as_sum_i[W-1];
            sreg_o[SB_S] = as_sum_i[W-1] ^ as_ovf_i;
            sreg_o[SB_Z] = zero_as;
         end
         OP_SHR: begin
            res_o        = shr_i;
            we_o         = 1'b1;
            sreg_o[SB_C] = sh_bit_i;
            sreg_o[SB_N] = 1'b0;
            sreg_o[SB_V] = sh_bit_i;
            sreg_o[SB_S] = sh_bit_i;
            sreg_o[SB_Z] = zero_shr;
         end
         OP_RORC: begin
            res_o        = ror_i;
            we_o         = 1'b1;
            sreg_o[SB_C] = sh_bit_i;
            sreg_o[SB_N] = ror_i[W-1];
            sreg_o[SB_V] = ror_i[W-1] ^ sh_bit_i;
            sreg_o[SB_S] = sh_bit_i;
            sreg_o[SB_Z] = zero_ror;
         end
         OP_SWAP: begin
            res_o = swp_i;
            we_o  = 1'b1;
         end
         default: begin
            res_o = '0;
         end
      endcase
   end

endmodule

// File: rtl/alu8_core.sv
`timescale 1ns/1ps
module alu8_core
   import alu8_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [3:0]   op_i,
   input  logic [W-1:0] dst_i,
   input  logic [W-1:0] src_i,
   input  logic [7:0]   sreg_i,
   output logic [W-1:0] res_o,
   output logic [7:0]   sreg_o,
   output logic         we_o
);
   localparam logic [W-1:0] ONE     = W'(1);
   localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

   generate
      if (W < 4 || (W % 2) != 0) begin : g_bad_w
         $error("alu8_core: W must be even and at least 4");
      end
   endgenerate

   alu_op_e     op;
   as_ctl_t     ctl;
   logic [W-1:0] as_a, as_b, as_sum;
   logic         as_cin, as_co, as_hc, as_ovf;
   logic [W-1:0] shr, ror, swp;
   logic         sh_bit;

   assign op = alu_op_e'(op_i);

   // operand steering for the shared adder/subtractor
   always_comb begin
      ctl = '0;
      unique case (op)
         OP_ADDC:  ctl = '{sub: 1'b0, use_cin: 1'b1, zero_a: 1'b0, one_b: 1'b0, swap_ab: 1'b0};
         OP_CMPC:  ctl = '{sub: 1'b1, use_cin: 1'b1, zero_a: 1'b0, one_b: 1'b0, swap_ab: 1'b0};
         OP_CMPI:  ctl = '{sub: 1'b1, use_cin: 1'b0, zero_a: 1'b0, one_b: 1'b0, swap_ab: 1'b0};
         OP_SUBIC: ctl = '{sub: 1'b1, use_cin: 1'b1, zero_a: 1'b0, one_b: 1'b0, swap_ab: 1'b0};
         OP_INC:   ctl = '{sub: 1'b0, use_cin: 1'b0, zero_a: 1'b0, one_b: 1'b1, swap_ab: 1'b0};
         OP_NEG:   ctl = '{sub: 1'b1, use_cin: 1'b0, zero_a: 1'b1, one_b: 1'b0, swap_ab: 1'b1};
         default:  ctl = '0;
      endcase
   end

   always_comb begin
      as_a   = ctl.zero_a  ? '0    : dst_i;
      as_b   = ctl.one_b   ? ONE   : (ctl.swap_ab ? dst_i : src_i);
      as_cin = ctl.use_cin & sreg_i[SB_C];
   end

   alu8_addsub #(.W(W)) u_addsub (
      .a_i   (as_a),
      .b_i   (as_b),
      .cin_i (as_cin),
      .sub_i (ctl.sub),
      .sum_o (as_sum),
      .co_o  (as_co),
      .hc_o  (as_hc),
      .ovf_o (as_ovf)
   );

   alu8_shift #(.W(W)) u_shift (
      .a_i       (dst_i),
      .cin_i     (sreg_i[SB_C]),
      .shr_o     (shr),
      .ror_o     (ror),
      .swp_o     (swp),
      .out_bit_o (sh_bit)
   );

   alu8_flagmux #(.W(W)) u_flags (
      .op_i     (op),
      .sreg_i   (sreg_i),
      .as_sum_i (as_sum),
      .as_co_i  (as_co),
      .as_hc_i  (as_hc),
      .as_ovf_i (as_ovf),
      .shr_i    (shr),
      .ror_i    (ror),
      .swp_i    (swp),
      .sh_bit_i (sh_bit),
      .res_o    (res_o),
      .sreg_o   (sreg_o),
      .we_o     (we_o)
   );

   always_comb begin
      if (!$isunknown({op_i, dst_i, src_i, sreg_i})) begin
         // R1
         tbit_ibit_chk: assert (sreg_o[SB_I:SB_T] == sreg_i[SB_I:SB_T])
            else $error("T or I bit changed");
         // R4
         if (op == OP_CMPC || op == OP_CMPI) begin
            cmp_no_write_chk: assert (!we_o)
               else $error("compare requested a result write");
         end
         // R5
         if (op == OP_CMPC || op == OP_SUBIC) begin
            zero_sticky_chk: assert (!(sreg_o[SB_Z] && !sreg_i[SB_Z]))
               else $error("chained subtract raised Z");
         end
         // R6
         if (op == OP_INC) begin
            inc_keep_c_chk: assert (sreg_o[SB_C] == sreg_i[SB_C] && sreg_o[SB_H] == sreg_i[SB_H])
               else $error("increment touched C or H");
            inc_ovf_chk: assert (sreg_o[SB_V] == (dst_i == MAX_POS))
               else $error("increment overflow wrong");
         end
         // R8
         if (op == OP_RORC) begin
            ror_carry_chk: assert (res_o[W-1] == sreg_i[SB_C] && sreg_o[SB_C] == dst_i[0])
               else $error("rotate carry path wrong");
         end
         // R10
         if (op == OP_SWAP) begin
            swap_flags_chk: assert (sreg_o == sreg_i)
               else $error("swap changed flags");
         end
         // R11
         if (op_i > 4'd8) begin
            unused_op_chk: assert (!we_o && sreg_o == sreg_i && res_o == '0)
               else $error("unused code had an effect");
         end
      end
   end

endmodule

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
module sim_alu8_core;

   logic       clk = 1'b0;
   logic [3:0] op  = '0;
   logic [7:0] dst = '0;
   logic [7:0] src = '0;
   logic [7:0] sr  = '0;
   logic [7:0] res;
   logic [7:0] sro;
   logic       we;

   int total = 0;
   int bad   = 0;
   bit ended = 0;

   always #5 clk = ~clk;

   alu8_core #(.W(8)) u0 (
      .op_i   (op),
      .dst_i  (dst),
      .src_i  (src),
      .sreg_i (sr),
      .res_o  (res),
      .sreg_o (sro),
      .we_o   (we)
   );

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   task automatic apply(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                        input logic [7:0] f);
      @(posedge clk);
      #1;
      op = o; dst = a; src = b; sr = f;
      @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [7:0] er, input logic [7:0] es,
                        input logic ew);
      total++;
      if (res !== er || sro !== es || we !== ew) begin
         bad++;
         $display("FAIL %s op=%0d dst=%h src=%h sreg=%h: got res=%h sreg=%h we=%b, expected res=%h sreg=%h we=%b",
                  tag, op, dst, src, sr, res, sro, we, er, es, ew);
      end
   endtask

   function automatic string tag_of(input int o);
      case (o)
         0: return "R2 R1";
         1: return "R3 R4 R5";
         2: return "R3 R4 R5 (cmpi)";
         3: return "R3 R4 R5 (sbci)";
         4: return "R6";
         5: return "R7";
         6: return "R8";
         7: return "R9";
         8: return "R10";
         default: return "R11";
      endcase
   endfunction

   // behavioural model: returns {we, sreg, res}
   function automatic logic [16:0] model(input int o, input int a, input int b,
                                         input logic [7:0] f);
      int t, lo, sv, sa, sb, ci;
      logic [7:0] r, nf;
      logic w;
      nf = f; r = '0; w = 1'b0;
      sa = (a >= 128) ? a - 256 : a;
      sb = (b >= 128) ? b - 256 : b;
      case (o)
         0: begin
            ci = int'(f[0]);
            t = a + b + ci; lo = (a % 16) + (b % 16) + ci; sv = sa + sb + ci;
            r = t[7:0];
            nf[0] = (t > 255); nf[5] = (lo > 15); nf[3] = (sv > 127 || sv < -128);
            nf[1] = (r == 0);
            w = 1'b1;
         end
         1, 2, 3: begin
            ci = (o == 2) ? 0 : int'(f[0]);
            t = a - b - ci; lo = (a % 16) - (b % 16) - ci; sv = sa - sb - ci;
            r = t[7:0];
            nf[0] = (t < 0); nf[5] = (lo < 0); nf[3] = (sv > 127 || sv < -128);
            nf[1] = (o == 2) ? (r == 0) : (f[1] && r == 0);
            w = (o == 3);
         end
         4: begin
            t = a + 1; r = t[7:0];
            nf[3] = (a == 127); nf[1] = (r == 0);
            w = 1'b1;
         end
         5: begin
            r = 8'(a / 2);
            nf[0] = (a % 2 == 1); nf[1] = (r == 0);
            nf[3] = nf[0];
            w = 1'b1;
         end
         6: begin
            r = 8'(a / 2 + (f[0] ? 128 : 0));
            nf[0] = (a % 2 == 1); nf[1] = (r == 0);
            nf[3] = r[7] ^ nf[0];
            w = 1'b1;
         end
         7: begin
            t = 0 - a; lo = 0 - (a % 16); sv = 0 - sa;
            r = t[7:0];
            nf[0] = (t < 0); nf[5] = (lo < 0); nf[3] = (sv > 127);
            nf[1] = (r == 0);
            w = 1'b1;
         end
         8: begin
            r = 8'((a % 16) * 16 + a / 16);
            w = 1'b1;
         end
         default: begin
            r = '0; w = 1'b0;
         end
      endcase
      if (o <= 7) begin
         nf[2] = r[7];
         nf[4] = nf[2] ^ nf[3];
      end
      return {w, nf, r};
   endfunction

   function automatic logic [7:0] src_pick(input int k);
      case (k)
         16: return 8'h80;
         17: return 8'h7F;
         18: return 8'h01;
         19: return 8'h10;
         20: return 8'h0F;
         21: return 8'hFE;
         default: return 8'(k * 17);
      endcase
   endfunction

   task automatic run_model(input int o, input int a, input int b, input logic [7:0] f);
      logic [16:0] e;
      apply(4'(o), 8'(a), 8'(b), f);
      e = model(o, a, b, f);
      check(tag_of(o), e[7:0], e[15:8], e[16]);
   endtask

   // watchdog
   initial begin
      repeat (190000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: run did not end, got running, expected done");
      finish_run();
   end

   initial begin
      // all-zero inputs: add of zeros gives zero with only Z set
      apply(4'd0, 8'h00, 8'h00, 8'h00);
      check("R2 idle", 8'h00, 8'h02, 1'b1);

      // directed cases
      apply(4'd0, 8'd10, 8'd20, 8'h01);   check("R2 10+20+C", 8'd31, 8'h00, 1'b1);
      apply(4'd0, 8'd10, 8'd245, 8'h01);  check("R2 carry out", 8'h00, 8'h23, 1'b1);
      apply(4'd1, 8'h00, 8'h00, 8'h81);   check("R3 R4 cpc 0-0-C keeps I", 8'hFF, 8'hB5, 1'b0);
      apply(4'd1, 8'h01, 8'h01, 8'h00);   check("R5 cpc equal, Z in clear", 8'h00, 8'h00, 1'b0);
      apply(4'd1, 8'h01, 8'h01, 8'h02);   check("R5 cpc equal, Z in set", 8'h00, 8'h02, 1'b0);
      apply(4'd2, 8'h08, 8'h09, 8'h00);   check("R3 R4 cpi 8-9", 8'hFF, 8'h35, 1'b0);
      apply(4'd2, 8'h09, 8'h09, 8'h00);   check("R5 cpi equal sets Z", 8'h00, 8'h02, 1'b0);
      apply(4'd3, 8'h03, 8'h03, 8'h81);   check("R3 R4 sbci 3-3-C", 8'hFF, 8'hB5, 1'b1);
      apply(4'd4, 8'h7F, 8'h00, 8'h00);   check("R6 inc 7F", 8'h80, 8'h0C, 1'b1);
      apply(4'd4, 8'hFF, 8'h00, 8'h00);   check("R6 inc FF", 8'h00, 8'h02, 1'b1);
      apply(4'd4, 8'h7F, 8'h00, 8'h21);   check("R6 inc keeps C,H", 8'h80, 8'h2D, 1'b1);
      apply(4'd5, 8'h45, 8'h00, 8'h00);   check("R7 lsr 45", 8'h22, 8'h19, 1'b1);
      apply(4'd6, 8'h11, 8'h00, 8'h00);   check("R8 ror 11", 8'h08, 8'h19, 1'b1);
      apply(4'd6, 8'h10, 8'h00, 8'h01);   check("R8 ror C into msb", 8'h88, 8'h0C, 1'b1);
      apply(4'd7, 8'h56, 8'h00, 8'h00);   check("R9 neg 56", 8'hAA, 8'h35, 1'b1);
      apply(4'd7, 8'h80, 8'h00, 8'h00);   check("R9 neg 80", 8'h80, 8'h0D, 1'b1);
      apply(4'd7, 8'h00, 8'h00, 8'h01);   check("R9 neg 00", 8'h00, 8'h02, 1'b1);
      apply(4'd8, 8'hA5, 8'h00, 8'hFF);   check("R10 swap A5", 8'h5A, 8'hFF, 1'b1);
      apply(4'd12, 8'h33, 8'h44, 8'h5A);  check("R11 unused code", 8'h00, 8'h5A, 1'b0);

      // sweep: binary operations over every dst, boundary-rich src set, all C/Z pairs
      for (int o = 0; o < 4; o++)
         for (int a = 0; a < 256; a++)
            for (int k = 0; k < 22; k++)
               for (int fc = 0; fc < 4; fc++)
                  run_model(o, a, int'(src_pick(k)),
                            {6'((a * 7 + k * 13 + fc) & 63), 2'(fc)});

      // sweep: unary operations over every dst, all C/Z pairs, varied upper flags (R1)
      for (int o = 4; o < 9; o++)
         for (int a = 0; a < 256; a++)
            for (int fc = 0; fc < 4; fc++)
               run_model(o, a, (a * 3) & 255, {6'((a + o * 5 + fc) & 63), 2'(fc)});

      // unused codes (R11)
      for (int o = 9; o < 16; o++)
         for (int a = 0; a < 64; a++)
            run_model(o, a * 4 + 1, 255 - a, 8'(a * 5));

      finish_run();
   end

endmodule